// File: doc/BRIEF.md
# Configuration Transaction Timeout Watchdog

This block sits on the path from a configuration proxy to a target port and supervises each read or write transaction that passes through it. Only one transaction is outstanding at a time. The proxy hands a request over on a valid/ready handshake. The block forwards the request to the target and waits for the target's single-cycle response. It then returns that response to the proxy.

If the target has not answered within a programmable number of clock cycles, the block answers the proxy itself with zero data and an error indication. It also sets a sticky timeout flag. Any response the target produces later for the abandoned transaction is swallowed. A new request is admitted only after that late response arrives, or after one further period has elapsed. The period and the flag share one 32-bit control/status word, accessed through a simple write strobe and a read-data bus.

Top module: `cfg_txn_watchdog`

## Requirements
- R1: After reset, `csr_rdata` reads 0x0000_0400: the period field (bits 15:0) is 0x400 and the flag (bit 31) is 0. Also after reset, `req_ready` is 1, `tgt_valid` is 0 and `rsp_valid` is 0.
- R2: A request is accepted in a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only when nothing is outstanding. In the next cycle, `tgt_valid` rises with the captured write bit, address and write data, and these hold steady until `tgt_ready` is seen.
- R3: Cycles after acceptance are numbered from 1. If the target responds (`tgt_rvalid`) in cycle k, with k no larger than the period P, then `rsp_valid` is high for exactly one cycle, in cycle k+1. It carries the target's data and error bit, for reads and writes alike.
- R4: If the first P cycles pass without a response, `rsp_valid` is high in cycle P+1 with `rsp_rdata` = 0 and `rsp_err` = 1, and bit 31 of the register becomes 1. This holds for reads and writes, whether or not the target has taken the request.
- R5: A response arriving in cycle P itself counts as a normal completion.
- R6: A period of 0 acts as a period of 1.
- R7: After a timeout during which the target had taken the request, the late target response produces no `rsp_valid`. While that response is awaited, `req_ready` stays low. The wait ends with the late response or after P further cycles, whichever comes first.
- R8: The flag is sticky. A register write with bit 31 = 0 clears it, and a write with bit 31 = 1 leaves it unchanged. A timeout in the same cycle as a clearing write leaves the flag set.
- R9: A register write loads the period from bits 15:0. Bits 30:16 always read 0 and ignore written values.
- R10: A timeout before the target has taken the request withdraws it. In cycle P+1, `tgt_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Proxy request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | One-cycle response to the proxy |
| rsp_rdata | output | DATA_W | Response data (0 on timeout) |
| rsp_err | output | 1 | Response error (1 on timeout) |
| tgt_valid | output | 1 | Request presented to the target |
| tgt_ready | input | 1 | Target takes the request |
| tgt_write | output | 1 | Forwarded write bit |
| tgt_addr | output | ADDR_W | Forwarded address |
| tgt_wdata | output | DATA_W | Forwarded write data |
| tgt_rvalid | input | 1 | One-cycle target response |
| tgt_rdata | input | DATA_W | Target response data |
| tgt_rerr | input | 1 | Target response error |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write value |
| csr_rdata | output | 32 | Register value: flag bit 31, period bits 15:0 |

## Verification
The assertions assume that the target raises `tgt_rvalid` only after it has taken a request, and at most once per request. They also assume that `tgt_ready` has no effect when `tgt_valid` is low. The stimulus models the target as a single sequential task. It asserts `tgt_ready` after a chosen delay and sends exactly one response after a further delay. It never starts a new request before the previous target activity has finished. The delays are chosen to land just inside, exactly at, and just past the period, and also inside the request phase.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;
  // sequencer phases: idle, request offered, response awaited, absorbing a late response
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OFFER = 2'd1,
    PH_AWAIT = 2'd2,
    PH_SINK  = 2'd3
  } wd_phase_e;

  localparam int CSR_W    = 32;
  localparam int FLAG_BIT = 31;
endpackage

// File: rtl/cfgwd_csr.sv
module cfgwd_csr #(
  parameter int          PERIOD_W   = 16,
  parameter int unsigned PERIOD_RST = 32'h400
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       csr_we,
  input  logic [cfgwd_pkg::CSR_W-1:0] csr_wdata,
  input  logic                       tout_evt,
  output logic [PERIOD_W-1:0]        period,
  output logic                       flag,
  output logic [cfgwd_pkg::CSR_W-1:0] csr_rdata
);
  import cfgwd_pkg::*;

  logic unused_wbits;
  assign unused_wbits = ^csr_wdata[FLAG_BIT-1:PERIOD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= PERIOD_W'(PERIOD_RST);
      flag   <= 1'b0;
    end else begin
      if (csr_we) period <= csr_wdata[PERIOD_W-1:0];
      // a new timeout outranks a software clear in the same cycle
      if (tout_evt)                             flag <= 1'b1;
      else if (csr_we && !csr_wdata[FLAG_BIT])  flag <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata                 = '0;
    csr_rdata[PERIOD_W-1:0]   = period;
    csr_rdata[FLAG_BIT]       = flag;
  end

  // R8: the flag only drops after a clearing write
  p_flag_clear_sw_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(csr_we && !csr_wdata[FLAG_BIT]));
  // R8: writing a one never clears the flag
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && csr_we && csr_wdata[FLAG_BIT]) |=> flag);
endmodule

// File: rtl/cfgwd_timer.sv
module cfgwd_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                hit
);
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W:0]   elapsed;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (run && (cnt != '1))   cnt <= cnt + 1'b1;
  end

  // cycles spent so far including the current one; period 0 behaves as 1
  assign elapsed = {1'b0, cnt} + {{PERIOD_W{1'b0}}, 1'b1};
  assign hit     = elapsed >= {1'b0, period};
endmodule

// File: rtl/cfgwd_seq.sv
module cfgwd_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic              tgt_write,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_rvalid,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_rerr,
  input  logic              hit,
  output logic              tmr_restart,
  output logic              tmr_run,
  output logic              tout_evt
);
  import cfgwd_pkg::*;

  wd_phase_e phase, phase_nx;
  logic      accept, done_ok;

  assign req_ready = (phase == PH_IDLE);
  assign tgt_valid = (phase == PH_OFFER);
  assign accept    = req_ready && req_valid;
  assign done_ok   = (phase == PH_AWAIT) && tgt_rvalid;
  assign tout_evt  = hit && ((phase == PH_OFFER) ||
                             ((phase == PH_AWAIT) && !tgt_rvalid));
  assign tmr_run   = (phase != PH_IDLE);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (accept) phase_nx = PH_OFFER;
      PH_OFFER: begin
        if (hit)            phase_nx = tgt_ready ? PH_SINK : PH_IDLE;
        else if (tgt_ready) phase_nx = PH_AWAIT;
      end
      PH_AWAIT: begin
        if (tgt_rvalid)     phase_nx = PH_IDLE;
        else if (hit)       phase_nx = PH_SINK;
      end
      PH_SINK:  if (tgt_rvalid || hit) phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  // timer restarts on acceptance and again when the late-response wait begins
  assign tmr_restart = accept || (tout_evt && (phase_nx == PH_SINK));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      tgt_write <= 1'b0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
    end else begin
      phase     <= phase_nx;
      rsp_valid <= done_ok || tout_evt;
      if (done_ok) begin
        rsp_rdata <= tgt_rdata;
        rsp_err   <= tgt_rerr;
      end else if (tout_evt) begin
        rsp_rdata <= '0;
        rsp_err   <= 1'b1;
      end
      if (accept) begin
        tgt_write <= req_write;
        tgt_addr  <= req_addr;
        tgt_wdata <= req_wdata;
      end
    end
  end

  // R2: an accepted request is offered to the target next cycle
  p_accept_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> tgt_valid);
  // R2: an unaccepted offer stays put unless the timer withdraws it
  p_offer_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && !tgt_ready && !hit) |=>
      (tgt_valid && $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_write)));
  // R3: each response to the proxy lasts one cycle
  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R7: a late target response is swallowed
  p_drop_late_r7: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_SINK) && tgt_rvalid) |=> (!rsp_valid && req_ready));
endmodule

// File: rtl/cfg_txn_watchdog.sv
module cfg_txn_watchdog #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          PERIOD_W   = 16,
  parameter int unsigned PERIOD_RST = 32'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic              tgt_write,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_rvalid,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_rerr,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata
);
  logic [PERIOD_W-1:0] period;
  logic                tout_flag, tout_evt, hit, tmr_restart, tmr_run;

  cfgwd_csr #(.PERIOD_W(PERIOD_W), .PERIOD_RST(PERIOD_RST)) u_csr (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .tout_evt(tout_evt), .period(period), .flag(tout_flag), .csr_rdata(csr_rdata)
  );

  cfgwd_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .restart(tmr_restart), .run(tmr_run),
    .period(period), .hit(hit)
  );

  cfgwd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_write(tgt_write),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_rvalid(tgt_rvalid), .tgt_rdata(tgt_rdata), .tgt_rerr(tgt_rerr),
    .hit(hit), .tmr_restart(tmr_restart), .tmr_run(tmr_run), .tout_evt(tout_evt)
  );

  // R4: the flag rises together with a locally generated error response
  p_flag_rsp_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tout_flag) |-> (rsp_valid && rsp_err && (rsp_rdata == '0)));
endmodule

// File: tb/sim_cfg_txn_watchdog.sv
module sim_cfg_txn_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, tgt_valid, tgt_write;
  logic [DW-1:0] rsp_rdata, tgt_wdata;
  logic [AW-1:0] tgt_addr;
  logic tgt_ready = 1'b0, tgt_rvalid = 1'b0, tgt_rerr = 1'b0;
  logic [DW-1:0] tgt_rdata = '0;
  logic csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;

  cfg_txn_watchdog u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_write(tgt_write),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_rvalid(tgt_rvalid), .tgt_rdata(tgt_rdata), .tgt_rerr(tgt_rerr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    int            at;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_rsp = 0, n_push = 0;
  int last_a = -100000;
  int probe_lo = 0, probe_hi = 0, probe_clr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected response", rsp_rdata, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e.data, e.tag, "rsp data", rsp_rdata, e.data);
        chk(rsp_err == e.err, e.tag, "rsp err", 32'(rsp_err), 32'(e.err));
        chk(cyc == e.at, e.tag, "rsp cycle", 32'(cyc), 32'(e.at));
      end
    end
  end

  // probes tied to the acceptance cycle of the current transaction
  always @(negedge clk) begin
    if (probe_lo != 0 && cyc == last_a + probe_lo)
      chk(req_ready == 1'b0, "R7", "ready low while awaiting late rsp", 32'(req_ready), 32'h0);
    if (probe_hi != 0 && cyc == last_a + probe_hi)
      chk(req_ready == 1'b1 && tgt_valid == 1'b0, "R10", "ready/valid after expiry",
          {30'h0, req_ready, tgt_valid}, 32'h2);
    if (probe_clr != 0 && cyc == last_a + probe_clr) begin
      csr_we    <= 1'b1;
      csr_wdata <= 32'h0000_0010;
    end else if (probe_clr != 0 && cyc == last_a + probe_clr + 1) begin
      csr_we    <= 1'b0;
    end
  end

  task automatic csr_write(input logic [31:0] v);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // driver: one transaction plus the target's behaviour; rsp < 0 means never answer
  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int rdy, input int rsp, input logic [DW-1:0] rd,
                         input bit re, input int per, input string tag);
    int k, peff, acc;
    exp_t e;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    last_a = acc;
    chk(tgt_valid && tgt_addr == a && tgt_wdata == wd && tgt_write == wr, "R2",
        "forwarded request", tgt_wdata, wd);
    k    = (rsp < 0) ? (1 << 30) : (rdy + 2 + rsp);
    peff = (per == 0) ? 1 : per;
    e.tag = tag;
    if (k <= peff) begin e.data = rd;  e.err = re;   e.at = acc + k;    end
    else           begin e.data = '0;  e.err = 1'b1; e.at = acc + peff; end
    exp_q.push_back(e);
    n_push++;
    repeat (rdy) @(negedge clk);
    tgt_ready = 1'b1;
    @(negedge clk);
    tgt_ready = 1'b0;
    if (rsp >= 0) begin
      repeat (rsp) @(negedge clk);
      tgt_rvalid = 1'b1; tgt_rdata = rd; tgt_rerr = re;
      @(negedge clk);
      tgt_rvalid = 1'b0; tgt_rdata = '0; tgt_rerr = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(csr_rdata == 32'h0000_0400, "R1", "csr reset", csr_rdata, 32'h0000_0400);
    chk(req_ready && !tgt_valid && !rsp_valid, "R1", "handshake reset",
        {29'h0, req_ready, tgt_valid, rsp_valid}, 32'h4);

    // R9 period load, upper bits ignored; R8 writing one to a clear flag leaves it 0
    csr_write(32'hFFFF_0010);
    chk(csr_rdata == 32'h0000_0010, "R9", "period write", csr_rdata, 32'h0000_0010);

    // R3 normal read and write
    run_txn(1'b0, 16'h0040, 32'h0, 0, 3, 32'hA5A5_0001, 1'b0, 16, "R3");
    run_txn(1'b1, 16'h0044, 32'h1234_5678, 2, 1, 32'h0000_00FF, 1'b1, 16, "R3");
    chk(csr_rdata[31] == 1'b0, "R3", "no flag on normal completion", csr_rdata, 32'h10);

    // R5 response exactly at cycle P
    run_txn(1'b0, 16'h0048, 32'h0, 3, 11, 32'hCAFE_0005, 1'b0, 16, "R5");
    chk(csr_rdata[31] == 1'b0, "R5", "no flag at boundary", csr_rdata, 32'h10);

    // R4/R7 one cycle late: timeout then dropped late response
    run_txn(1'b0, 16'h004C, 32'h0, 3, 12, 32'hDEAD_0007, 1'b0, 16, "R4");
    chk(csr_rdata == 32'h8000_0010, "R4", "flag after timeout", csr_rdata, 32'h8000_0010);

    // R8 sticky flag
    csr_write(32'h8000_0010);
    chk(csr_rdata == 32'h8000_0010, "R8", "write one keeps flag", csr_rdata, 32'h8000_0010);
    csr_write(32'h0000_0010);
    chk(csr_rdata == 32'h0000_0010, "R8", "write zero clears flag", csr_rdata, 32'h0000_0010);

    // R10 expiry while the target never takes the request (write)
    last_a = -100000; probe_hi = 16;
    run_txn(1'b1, 16'h0050, 32'h0BAD_F00D, 30, 0, 32'h1111_1111, 1'b0, 16, "R10");
    probe_hi = 0;
    chk(csr_rdata[31] == 1'b1, "R4", "flag after write timeout", csr_rdata, 32'h8000_0010);
    csr_write(32'h0000_0010);

    // R7 target took the request and never answers: ready held low for P more cycles
    last_a = -100000; probe_lo = 31; probe_hi = 32;
    run_txn(1'b0, 16'h0054, 32'h0, 0, -1, 32'h0, 1'b0, 16, "R7");
    repeat (20) @(negedge clk);
    probe_lo = 0; probe_hi = 0;
    csr_write(32'h0000_0000);
    chk(csr_rdata == 32'h0, "R9", "period zero written", csr_rdata, 32'h0);

    // R6 period 0 behaves as 1
    run_txn(1'b0, 16'h0058, 32'h0, 0, 0, 32'h2222_2222, 1'b0, 0, "R6");
    chk(csr_rdata == 32'h8000_0000, "R6", "flag with zero period", csr_rdata, 32'h8000_0000);
    csr_write(32'h0000_0010);

    // R8 clearing write in the expiry cycle loses to the new timeout
    last_a = -100000; probe_clr = 15;
    run_txn(1'b1, 16'h005C, 32'h3333_3333, 0, -1, 32'h0, 1'b0, 16, "R8");
    repeat (20) @(negedge clk);
    probe_clr = 0;
    chk(csr_rdata == 32'h8000_0010, "R8", "set wins over clear", csr_rdata, 32'h8000_0010);

    // R1 default period after a fresh reset
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(csr_rdata == 32'h0000_0400, "R1", "csr after second reset", csr_rdata, 32'h0000_0400);
    run_txn(1'b0, 16'h0060, 32'h0, 0, -1, 32'h0, 1'b0, 1024, "R1");
    run_txn(1'b0, 16'h0064, 32'h0, 1, 2, 32'h4444_4444, 1'b0, 1024, "R3");

    chk(n_rsp == n_push, "R7", "response count", 32'(n_rsp), 32'(n_push));
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule